// File: doc/BRIEF.md
# Device Interrupt Status Aggregator

This block gathers the event and state lines of a full-speed USB device controller into one 8-bit interrupt status register and one interrupt request pin for the local processor. Each status bit is a source condition ANDed with its bit in an 8-bit enable register. Receive-side sources and the suspend line are copied as they are. Transmit-side sources are inverted, so that an empty transmit buffer, which is waiting for the processor to fill it, raises the bit. The two bulk endpoints take their condition from the receive or the transmit side, depending on the direction each endpoint is configured for.

The bus-reset condition behaves differently. A bus-reset pulse sets a sticky latch, but only while its enable bit is set. The latch stays set until software writes a one to a clear bit that sits in a separate device-state register. The interrupt pin is registered. It is asserted whenever any status bit is set, and a polarity register selects whether it is active low or active high.

The processor reaches the block through a simple register port: an address, a write strobe with write data, and a combinational read-data output.

Top module: `usbirq_top`

## Requirements
- R1: After reset, the enable register reads 01h, the polarity register reads 00h (active low), and `intr_o` is high (deasserted).
- R2: Status bit 0 (setup ready) and status bit 3 (control-endpoint receive ready) each equal their input ANDed with the enable bit at the same position.
- R3: Status bit 4 (control-endpoint transmit) and status bit 7 (interrupt endpoint) each equal the inverse of their transmit-ready input ANDed with the enable bit.
- R4: Status bits 1 and 2 (bulk endpoints A and B) follow the receive-ready input when the endpoint's direction input is 0 (OUT). They follow the inverse of the transmit-ready input when the direction input is 1 (IN). The unselected input has no effect.
- R5: Status bit 6 follows the suspended input, gated by enable bit 6.
- R6: A `bus_reset_i` pulse sets status bit 5 at the next clock edge when enable bit 5 is 1, and leaves it at 0 when enable bit 5 is 0. Once set, bit 5 stays set even if enable bit 5 is later cleared.
- R7: Status bit 5 clears only on a write to the device-state address (01h) with data bit 5 set. Writing 0 there has no effect. A bus-reset pulse in the same cycle as the clear leaves the bit set. The device-state address always reads 00h.
- R8: `intr_o` is registered and changes one clock after the status changes. It is at the active level while any status bit is 1. Polarity register bit 0 selects the active level: 0 means active low, 1 means active high.
- R9: The status register at address 11h is read-only. Writes to it change neither the status, the enable register nor the polarity register.
- R10: The enable register (address 10h) and polarity bit 0 (address 12h) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address for both reads and writes |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i`, combinational |
| setup_rdy_i | input | 1 | A setup packet is waiting |
| ep0_rx_rdy_i | input | 1 | Control endpoint has a received packet |
| ep0_tx_rdy_i | input | 1 | Control endpoint transmit buffer is armed |
| ep1_dir_in_i | input | 1 | Bulk endpoint A direction (1 = IN) |
| ep1_rx_rdy_i | input | 1 | Bulk endpoint A has a received packet |
| ep1_tx_rdy_i | input | 1 | Bulk endpoint A transmit buffer is armed |
| ep2_dir_in_i | input | 1 | Bulk endpoint B direction (1 = IN) |
| ep2_rx_rdy_i | input | 1 | Bulk endpoint B has a received packet |
| ep2_tx_rdy_i | input | 1 | Bulk endpoint B transmit buffer is armed |
| ep3_tx_rdy_i | input | 1 | Interrupt endpoint transmit buffer is armed |
| suspended_i | input | 1 | Device is suspended |
| bus_reset_i | input | 1 | Bus reset detected, one-cycle pulse |
| intr_o | output | 1 | Interrupt request, registered, programmable polarity |

## Verification
The bench targets the cases where bits are easy to get wrong:
- Inverted transmit sources: a design that forgot the inversion would show bits 4 and 7 set exactly when the buffers are armed.
- Bulk direction switch: a design that ignored the direction input would keep following the receive line on an IN endpoint.
- Bus-reset latch: this is checked for setting while enabled and staying clear while disabled, for surviving a later disable, for ignoring a write of 0, and for a pulse and a clear in the same cycle. A design that let the clear win would lose that event.
- Polarity and read-only status: the bench flips the polarity and writes to the status address. A wrong design would leave the pin stuck at one level or let the write corrupt the enable register.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

    // Number of interrupt sources; equals the register data width.
    localparam int unsigned SRC_N  = 8;
    // Number of bulk endpoints whose source depends on direction.
    localparam int unsigned BULK_N = 2;

    // Status / enable bit positions (decoded by software, so fixed).
    localparam int unsigned B_SETUP  = 0;
    localparam int unsigned B_EP1    = 1;
    localparam int unsigned B_EP2    = 2;
    localparam int unsigned B_EP0RX  = 3;
    localparam int unsigned B_EP0TX  = 4;
    localparam int unsigned B_BUSRST = 5;
    localparam int unsigned B_SUSP   = 6;
    localparam int unsigned B_EP3    = 7;

    typedef struct packed {
        logic [SRC_N-1:0] en;       // per-source enable
        logic             pol_hi;   // 1: interrupt pin active high
        logic             busrst;   // sticky bus-reset latch
        logic             intr;     // registered pin level
    } irq_state_t;

endpackage

// File: rtl/usbirq_dirsel.sv
// Picks the ready condition of one bulk endpoint from its direction.
module usbirq_dirsel (
    input  logic dir_in_i,
    input  logic rx_rdy_i,
    input  logic tx_rdy_i,
    output logic ready_o
);
    always_comb begin
        if (dir_in_i) begin
            ready_o = ~tx_rdy_i;   // IN: buffer empty wants refill
        end else begin
            ready_o = rx_rdy_i;    // OUT: packet waiting to be read
        end
    end
endmodule

// File: rtl/usbirq_srcmap.sv
// Places every raw source condition at its status bit position.
module usbirq_srcmap
    import usbirq_pkg::*;
(
    input  logic              setup_rdy_i,
    input  logic              ep0_rx_rdy_i,
    input  logic              ep0_tx_rdy_i,
    input  logic [BULK_N-1:0] bulk_dir_in_i,
    input  logic [BULK_N-1:0] bulk_rx_rdy_i,
    input  logic [BULK_N-1:0] bulk_tx_rdy_i,
    input  logic              ep3_tx_rdy_i,
    input  logic              suspended_i,
    input  logic              busrst_latched_i,
    output logic [SRC_N-1:0]  raw_o
);
    logic [BULK_N-1:0] bulk_ready;

    for (genvar g = 0; g < BULK_N; g++) begin : g_bulk
        usbirq_dirsel u_dirsel (
            .dir_in_i (bulk_dir_in_i[g]),
            .rx_rdy_i (bulk_rx_rdy_i[g]),
            .tx_rdy_i (bulk_tx_rdy_i[g]),
            .ready_o  (bulk_ready[g])
        );
    end

    always_comb begin
        raw_o           = '0;
        raw_o[B_SETUP]  = setup_rdy_i;
        raw_o[B_EP1]    = bulk_ready[0];
        raw_o[B_EP2]    = bulk_ready[1];
        raw_o[B_EP0RX]  = ep0_rx_rdy_i;
        raw_o[B_EP0TX]  = ~ep0_tx_rdy_i;
        raw_o[B_BUSRST] = busrst_latched_i;
        raw_o[B_SUSP]   = suspended_i;
        raw_o[B_EP3]    = ~ep3_tx_rdy_i;
    end
endmodule

// File: rtl/usbirq_gate.sv
// Applies the enable mask; the sticky bit was gated when it was latched.
module usbirq_gate
    import usbirq_pkg::*;
(
    input  logic [SRC_N-1:0] raw_i,
    input  logic [SRC_N-1:0] en_i,
    output logic [SRC_N-1:0] status_o
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        if (i == B_BUSRST) begin : g_sticky
            logic unused_en;
            assign unused_en   = en_i[i];
            assign status_o[i] = raw_i[i];
        end else begin : g_live
            assign status_o[i] = raw_i[i] & en_i[i];
        end
    end
endmodule

// File: rtl/usbirq_top.sv
module usbirq_top
    import usbirq_pkg::*;
#(
    parameter int unsigned         ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]   ADDR_DEVST = 8'h01,
    parameter logic [ADDR_W-1:0]   ADDR_EN    = 8'h10,
    parameter logic [ADDR_W-1:0]   ADDR_STAT  = 8'h11,
    parameter logic [ADDR_W-1:0]   ADDR_POL   = 8'h12,
    parameter logic [SRC_N-1:0]    EN_RST     = 8'h01,
    parameter int unsigned         CLR_BIT    = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [SRC_N-1:0]  wr_data_i,
    output logic [SRC_N-1:0]  rd_data_o,
    input  logic              setup_rdy_i,
    input  logic              ep0_rx_rdy_i,
    input  logic              ep0_tx_rdy_i,
    input  logic              ep1_dir_in_i,
    input  logic              ep1_rx_rdy_i,
    input  logic              ep1_tx_rdy_i,
    input  logic              ep2_dir_in_i,
    input  logic              ep2_rx_rdy_i,
    input  logic              ep2_tx_rdy_i,
    input  logic              ep3_tx_rdy_i,
    input  logic              suspended_i,
    input  logic              bus_reset_i,
    output logic              intr_o
);
    localparam irq_state_t ST_RST = '{en: EN_RST, pol_hi: 1'b0,
                                      busrst: 1'b0, intr: 1'b1};

    irq_state_t        st_d, st_q;
    logic [SRC_N-1:0]  raw_w;
    logic [SRC_N-1:0]  status_w;
    logic [SRC_N-1:0]  en_w;
    logic              pol_w;

    assign en_w  = st_q.en;
    assign pol_w = st_q.pol_hi;

    usbirq_srcmap u_srcmap (
        .setup_rdy_i      (setup_rdy_i),
        .ep0_rx_rdy_i     (ep0_rx_rdy_i),
        .ep0_tx_rdy_i     (ep0_tx_rdy_i),
        .bulk_dir_in_i    ({ep2_dir_in_i, ep1_dir_in_i}),
        .bulk_rx_rdy_i    ({ep2_rx_rdy_i, ep1_rx_rdy_i}),
        .bulk_tx_rdy_i    ({ep2_tx_rdy_i, ep1_tx_rdy_i}),
        .ep3_tx_rdy_i     (ep3_tx_rdy_i),
        .suspended_i      (suspended_i),
        .busrst_latched_i (st_q.busrst),
        .raw_o            (raw_w)
    );

    usbirq_gate u_gate (
        .raw_i    (raw_w),
        .en_i     (en_w),
        .status_o (status_w)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (wr_en_i && addr_i == ADDR_EN) begin
            st_d.en = wr_data_i;
        end
        if (wr_en_i && addr_i == ADDR_POL) begin
            st_d.pol_hi = wr_data_i[0];
        end
        if (wr_en_i && addr_i == ADDR_DEVST && wr_data_i[CLR_BIT]) begin
            st_d.busrst = 1'b0;
        end
        // A new bus reset outranks a clear in the same cycle.
        if (bus_reset_i && st_q.en[B_BUSRST]) begin
            st_d.busrst = 1'b1;
        end
        st_d.intr = (|status_w) ? st_q.pol_hi : ~st_q.pol_hi;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux
    always_comb begin
        rd_data_o = '0;
        if (addr_i == ADDR_EN) begin
            rd_data_o = en_w;
        end else if (addr_i == ADDR_STAT) begin
            rd_data_o = status_w;
        end else if (addr_i == ADDR_POL) begin
            rd_data_o[0] = pol_w;
        end
    end

    assign intr_o = st_q.intr;

endmodule

// File: rtl/usbirq_chk.sv
module usbirq_chk
    import usbirq_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] ADDR_DEVST = 8'h01,
    parameter logic [ADDR_W-1:0] ADDR_STAT  = 8'h11,
    parameter int unsigned       CLR_BIT    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [SRC_N-1:0]  wr_data,
    input logic              bus_reset,
    input logic [SRC_N-1:0]  stat,
    input logic [SRC_N-1:0]  en_q,
    input logic              pol_q,
    input logic              intr
);
    logic clr_wr;
    assign clr_wr = wr_en && (addr == ADDR_DEVST) && wr_data[CLR_BIT];

    AST_INTR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat) |=> (intr == $past(pol_q)));                           // R8
    AST_INTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |=> (intr == !$past(pol_q)));                     // R8
    AST_BUSRST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && en_q[B_BUSRST]) |=> stat[B_BUSRST]);             // R6
    AST_BUSRST_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[B_BUSRST] && !(bus_reset && en_q[B_BUSRST]))
            |=> !stat[B_BUSRST]);                                      // R6
    AST_BUSRST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[B_BUSRST] && !clr_wr) |=> stat[B_BUSRST]);               // R7
    AST_BUSRST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !bus_reset) |=> !stat[B_BUSRST]);                   // R7
    AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~en_q & ~(SRC_N'(1) << B_BUSRST)) == '0));            // R2
    AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STAT) |=> ($stable(en_q) && $stable(pol_q))); // R9

endmodule

bind usbirq_top usbirq_chk #(
    .ADDR_W     (ADDR_W),
    .ADDR_DEVST (ADDR_DEVST),
    .ADDR_STAT  (ADDR_STAT),
    .CLR_BIT    (CLR_BIT)
) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .addr      (addr_i),
    .wr_en     (wr_en_i),
    .wr_data   (wr_data_i),
    .bus_reset (bus_reset_i),
    .stat      (status_w),
    .en_q      (en_w),
    .pol_q     (pol_w),
    .intr      (intr_o)
);

// File: tb/usbirq_top_test.sv
module usbirq_top_test;

    localparam logic [7:0] A_DEVST = 8'h01;
    localparam logic [7:0] A_EN    = 8'h10;
    localparam logic [7:0] A_STAT  = 8'h11;
    localparam logic [7:0] A_POL   = 8'h12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic setup = 0, ep0rx = 0, ep0tx = 0, ep1dir = 0, ep1rx = 0, ep1tx = 0;
    logic ep2dir = 0, ep2rx = 0, ep2tx = 0, ep3tx = 0, susp = 0, busrst = 0;
    logic intr;

    always #2 clk = ~clk;   // 250 MHz

    usbirq_top uut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_data_o(rd_data),
        .setup_rdy_i(setup), .ep0_rx_rdy_i(ep0rx), .ep0_tx_rdy_i(ep0tx),
        .ep1_dir_in_i(ep1dir), .ep1_rx_rdy_i(ep1rx), .ep1_tx_rdy_i(ep1tx),
        .ep2_dir_in_i(ep2dir), .ep2_rx_rdy_i(ep2rx), .ep2_tx_rdy_i(ep2tx),
        .ep3_tx_rdy_i(ep3tx), .suspended_i(susp), .bus_reset_i(busrst),
        .intr_o(intr)
    );

    typedef struct {
        bit         is_pin;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    // Monitor: compares one expected item per falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = it.is_pin ? {7'b0, intr} : rd_data;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [7:0] e, input string t);
        item_t it;
        addr = a;
        it.is_pin = 1'b0; it.exp = e; it.tag = t;
        q.push_back(it);
        tick();
    endtask

    // Lets the registered pin settle for one edge, then checks it.
    task automatic chk_pin(input logic e, input string t);
        item_t it;
        tick();
        it.is_pin = 1'b1; it.exp = {7'b0, e}; it.tag = t;
        q.push_back(it);
        tick();
    endtask

    task automatic pulse_busrst();
        busrst = 1'b1;
        tick();
        busrst = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk_rd(A_EN,   8'h01, "R1 enable reset");
        chk_rd(A_POL,  8'h00, "R1 polarity reset");
        chk_rd(A_STAT, 8'h00, "R1 status reset");
        chk_pin(1'b1, "R1 pin idle high");

        // R2 setup ready, R8 active-low assertion
        setup = 1;
        chk_rd(A_STAT, 8'h01, "R2 setup ready");
        chk_pin(1'b0, "R8 pin active low");

        // R10 enable readback; R3 inverted transmit sources
        wr(A_EN, 8'hFF);
        chk_rd(A_EN, 8'hFF, "R10 enable readback");
        chk_rd(A_STAT, 8'h91, "R3 tx empty raises bits 4 and 7");
        ep0tx = 1; ep3tx = 1; ep0rx = 1;
        chk_rd(A_STAT, 8'h09, "R2 R3 ep0 rx set, tx armed");

        // R4 bulk direction selection
        ep1rx = 1; ep2dir = 1;
        chk_rd(A_STAT, 8'h0F, "R4 OUT rx, IN tx empty");
        ep1dir = 1; ep1tx = 1; ep2tx = 1;
        chk_rd(A_STAT, 8'h09, "R4 IN ignores rx line");

        // R5 suspended mirror
        susp = 1;
        chk_rd(A_STAT, 8'h49, "R5 suspended set");
        susp = 0;
        chk_rd(A_STAT, 8'h09, "R5 suspended clear");

        setup = 0; ep0rx = 0;
        chk_rd(A_STAT, 8'h00, "R2 sources cleared");
        chk_pin(1'b1, "R8 pin released");

        // R6 / R7 sticky bus reset
        pulse_busrst();
        chk_rd(A_STAT, 8'h20, "R6 bus reset latched");
        chk_pin(1'b0, "R8 pin from bus reset");
        wr(A_DEVST, 8'h00);
        chk_rd(A_STAT, 8'h20, "R7 write zero keeps latch");
        chk_rd(A_DEVST, 8'h00, "R7 device state reads zero");
        wr(A_DEVST, 8'h20);
        chk_rd(A_STAT, 8'h00, "R7 clear by write one");

        wr(A_EN, 8'hDF);
        pulse_busrst();
        chk_rd(A_STAT, 8'h00, "R6 disabled pulse ignored");

        wr(A_EN, 8'hFF);
        busrst = 1'b1;
        wr(A_DEVST, 8'h20);
        busrst = 1'b0;
        chk_rd(A_STAT, 8'h20, "R7 set wins over clear");
        wr(A_EN, 8'h00);
        chk_rd(A_STAT, 8'h20, "R6 latch survives disable");
        wr(A_DEVST, 8'h20);
        chk_rd(A_STAT, 8'h00, "R7 cleared again");

        // R8 polarity
        wr(A_POL, 8'h01);
        chk_rd(A_POL, 8'h01, "R10 polarity readback");
        chk_pin(1'b0, "R8 active-high idle low");
        wr(A_EN, 8'h01);
        setup = 1;
        chk_pin(1'b1, "R8 active-high asserted");

        // R9 status is read-only
        wr(A_STAT, 8'hFE);
        chk_rd(A_EN,   8'h01, "R9 enable untouched");
        chk_rd(A_POL,  8'h01, "R9 polarity untouched");
        chk_rd(A_STAT, 8'h01, "R9 status unchanged");

        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual %h expected %h", 1'b0, 1'b1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule